// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Slave

This block sits between an external host processor bus and an on-chip register file. A static mode input picks one of two host protocols. In the clocked protocol, the host marks an access with an address strobe that is low for exactly one host clock. In the strobe-framed protocol, the address strobe stays low for the whole access, and a separate data strobe frames the data phase. The data strobe plays no part in the clocked protocol.

The host clock samples every host signal in both modes. In the strobe-framed mode, chip select and both strobes first pass through multi-flop synchronizers. An edge detector on the synchronized data strobe then starts a single internal access for each strobe assertion. Each accepted access produces a one-cycle internal read or write request that carries the captured address and write data. A small bank of test registers answers these requests. The block then raises an active-low acknowledge. On reads it also drives the read data together with a bus-drive enable, which stands in for the tri-state pad control. An access whose chip select is deasserted produces no effect at all.

Top module: `hbus_slave`

## Requirements
- R1: After reset, ack_no is 1, data_oe_o is 0, req_wr_o and req_rd_o are 0, and every bank register reads as 0.
- R2: In clocked mode (sync_mode_i = 1), a rising edge that samples as_ni = 0, cs_ni = 0 and rw_i = 0 produces req_wr_o = 1 for exactly the next cycle, with req_addr_o = addr_i and req_wdata_o = data_i as sampled on that edge. The addressed register takes the data.
- R3: In clocked mode, a read (rw_i = 1) produces req_rd_o for the cycle after the strobe edge. ack_no is then 0, with data_oe_o = 1 and data_o equal to the register, for exactly one cycle one edge later.
- R4: In clocked mode, ds_ni has no effect. A data strobe pulse with as_ni high creates no request and no acknowledge, and an access behaves the same whatever level ds_ni has.
- R5: An access with cs_ni = 1 creates no request and no acknowledge in either mode, and leaves the bank unchanged.
- R6: In strobe-framed mode (sync_mode_i = 0), when ds_ni falls while cs_ni and as_ni are low, the request is high in the cycle after the third rising edge following the fall. ack_no is low from the fourth edge on.
- R7: In strobe-framed mode, the address is held from addr_i while as_ni is low. The write data is taken from data_i on the edge at which the data strobe fall is detected.
- R8: In strobe-framed mode, ack_no stays low while ds_ni stays low. It returns to 1 after the third rising edge following the rise of ds_ni.
- R9: In strobe-framed mode, a data strobe held low for many cycles starts exactly one internal access.
- R10: Registers sit at full addresses 0 to NREG-1. Any other address reads as 0 and ignores writes, with no aliasing of the upper address bits.
- R11: data_oe_o is 1 only while ack_no is 0 for a read. A write acknowledge leaves data_oe_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock, samples all host signals |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | 1 = clocked protocol, 0 = strobe-framed protocol |
| cs_ni | input | 1 | Chip select, active low |
| as_ni | input | 1 | Address strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| ds_ni | input | 1 | Data strobe, active low (strobe-framed mode only) |
| addr_i | input | 21 | Host address |
| data_i | input | 16 | Host write data |
| data_o | output | 16 | Read data toward the host |
| data_oe_o | output | 1 | Bus drive enable; the bus floats when 0 |
| ack_no | output | 1 | Acknowledge, active low |
| req_wr_o | output | 1 | Internal write request, one cycle |
| req_rd_o | output | 1 | Internal read request, one cycle |
| req_addr_o | output | 21 | Captured address of the request |
| req_wdata_o | output | 16 | Captured write data of the request |

## Verification
In clocked mode the request is due one edge after the strobe edge, the acknowledge one edge after that, and the release one edge later still. In strobe-framed mode each strobe edge first crosses two synchronizer stages, so the request is due three edges after the data strobe falls and the acknowledge four edges after it. The release is due three edges after the data strobe rises. The bench drives every input on the falling clock edge and counts falling edges from the stimulus to sample each output in exactly its due cycle. It also samples the cycle just before, to show that the output has not yet moved. A running count of request cycles, taken on falling edges, proves that long strobes start one access and that deselected or ignored strobes start none.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic {
    MODE_ASYNC = 1'b0,
    MODE_SYNC  = 1'b1
  } hbus_mode_e;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int CW = STAGES * W;

  logic [CW-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[CW-W-1:0], d_i};
  end

  assign q_o = chain_q[CW-1 -: W];
endmodule

// File: rtl/hbus_front.sv
module hbus_front
  import hbus_pkg::*;
#(
  parameter int AW          = 21,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  hbus_mode_e    mode_i,
  input  logic          cs_ni,
  input  logic          as_ni,
  input  logic          rw_i,
  input  logic          ds_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          start_o,
  output logic          rd_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          ds_rel_o
);
  localparam int NCTL = 4;

  logic [NCTL-1:0] ctl_raw, ctl_syn;
  logic            cs_s, as_s, ds_s, rw_s;
  logic            ds_d_q;
  logic [AW-1:0]   addr_hold_q;
  logic            go, go_rd;
  logic [AW-1:0]   go_addr;
  logic            start_q, rd_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;

  assign ctl_raw = {rw_i, ds_ni, as_ni, cs_ni};

  hbus_sync #(
    .W      (NCTL),
    .STAGES (SYNC_STAGES),
    .RST_VAL({NCTL{1'b1}})
  ) u_ctl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_syn)
  );

  assign cs_s = ctl_syn[0];
  assign as_s = ctl_syn[1];
  assign ds_s = ctl_syn[2];
  assign rw_s = ctl_syn[3];

  // flop-based transparent hold: follows the bus while the strobe is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ds_d_q      <= 1'b1;
      addr_hold_q <= '0;
    end else begin
      ds_d_q <= ds_s;
      if (!as_ni) addr_hold_q <= addr_i;
    end
  end

  always_comb begin
    if (mode_i == MODE_SYNC) begin
      go      = ~as_ni & ~cs_ni;
      go_rd   = rw_i;
      go_addr = addr_i;
    end else begin
      go      = ds_d_q & ~ds_s & ~as_s & ~cs_s;
      go_rd   = rw_s;
      go_addr = addr_hold_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      start_q <= go;
      if (go) begin
        rd_q    <= go_rd;
        addr_q  <= go_addr;
        wdata_q <= data_i;
      end
    end
  end

  assign start_o  = start_q;
  assign rd_o     = rd_q;
  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
  assign ds_rel_o = ds_s;
endmodule

// File: rtl/hbus_regbank.sv
module hbus_regbank #(
  parameter int AW   = 21,
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int FW = NREG * DW;

  logic [FW-1:0] bank_flat;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] val_q;
    logic          hit;

    assign hit = (addr_i == AW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         val_q <= '0;
      else if (wr_i && hit) val_q <= wdata_i;
    end

    assign bank_flat[i*DW +: DW] = val_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr_i == AW'(i)) rdata_o = bank_flat[i*DW +: DW];
    end
  end
endmodule

// File: rtl/hbus_resp.sv
module hbus_resp
  import hbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  hbus_mode_e    mode_i,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          ds_rel_i,
  output logic          ack_no,
  output logic          data_oe_o,
  output logic [DW-1:0] data_o
);
  logic          ack_q, oe_q;
  logic [DW-1:0] rdata_q;
  logic          release_now;

  assign release_now = (mode_i == MODE_SYNC) | ds_rel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
      rdata_q <= '0;
    end else if (start_i) begin
      ack_q   <= 1'b1;
      oe_q    <= rd_i;
      rdata_q <= rd_i ? rdata_i : '0;
    end else if (ack_q && release_now) begin
      ack_q <= 1'b0;
      oe_q  <= 1'b0;
    end
  end

  assign ack_no    = ~ack_q;
  assign data_oe_o = oe_q;
  assign data_o    = oe_q ? rdata_q : '0;
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
  import hbus_pkg::*;
#(
  parameter int AW          = 21,
  parameter int DW          = 16,
  parameter int NREG        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_mode_i,
  input  logic          cs_ni,
  input  logic          as_ni,
  input  logic          rw_i,
  input  logic          ds_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          ack_no,
  output logic          req_wr_o,
  output logic          req_rd_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_wdata_o
);
  hbus_mode_e    mode;
  logic          start, rd;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_wdata, bank_rdata;
  logic          ds_rel;

  assign mode = hbus_mode_e'(sync_mode_i);

  hbus_front #(
    .AW         (AW),
    .DW         (DW),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .cs_ni   (cs_ni),
    .as_ni   (as_ni),
    .rw_i    (rw_i),
    .ds_ni   (ds_ni),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .start_o (start),
    .rd_o    (rd),
    .addr_o  (acc_addr),
    .wdata_o (acc_wdata),
    .ds_rel_o(ds_rel)
  );

  hbus_regbank #(
    .AW  (AW),
    .DW  (DW),
    .NREG(NREG)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (start & ~rd),
    .addr_i (acc_addr),
    .wdata_i(acc_wdata),
    .rdata_o(bank_rdata)
  );

  hbus_resp #(
    .DW(DW)
  ) u_resp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .start_i  (start),
    .rd_i     (rd),
    .rdata_i  (bank_rdata),
    .ds_rel_i (ds_rel),
    .ack_no   (ack_no),
    .data_oe_o(data_oe_o),
    .data_o   (data_o)
  );

  assign req_wr_o    = start & ~rd;
  assign req_rd_o    = start & rd;
  assign req_addr_o  = acc_addr;
  assign req_wdata_o = acc_wdata;
endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sync_mode_i,
  input logic cs_ni,
  input logic ds_ni,
  input logic req_wr_o,
  input logic req_rd_o,
  input logic ack_no,
  input logic data_oe_o
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_wr_o && req_rd_o)); // R2

  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_wr_o || req_rd_o) |=> !(req_wr_o || req_rd_o)); // R9

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_no) |-> $past(req_wr_o || req_rd_o)); // R3

  AST_SYNC_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && !ack_no) |=> ack_no); // R3

  AST_NO_SELECT_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && cs_ni) |=> !(req_wr_o || req_rd_o)); // R5

  AST_ASYNC_ACK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_mode_i && !ack_no && !$past(ds_ni, 2)) |=> !ack_no); // R8

  AST_DRIVE_ONLY_ACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !ack_no); // R11
endmodule

bind hbus_slave hbus_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sync_mode_i(sync_mode_i),
  .cs_ni      (cs_ni),
  .ds_ni      (ds_ni),
  .req_wr_o   (req_wr_o),
  .req_rd_o   (req_rd_o),
  .ack_no     (ack_no),
  .data_oe_o  (data_oe_o)
);

// File: tb/hbus_slave_test.sv
`timescale 1ns/1ps
module hbus_slave_test;
  localparam int AW   = 21;
  localparam int DW   = 16;
  localparam int NREG = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b1;
  logic          cs_n = 1'b1, as_n = 1'b1, rw = 1'b1, ds_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          oe, ack_n, req_wr, req_rd;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;

  int errs = 0, checks = 0, req_cnt = 0;
  logic [DW-1:0] rd_val;

  always #4 clk = ~clk;

  hbus_slave #(.AW(AW), .DW(DW), .NREG(NREG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sync_mode_i(mode),
    .cs_ni(cs_n), .as_ni(as_n), .rw_i(rw), .ds_ni(ds_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(oe),
    .ack_no(ack_n), .req_wr_o(req_wr), .req_rd_o(req_rd),
    .req_addr_o(req_addr), .req_wdata_o(req_wdata)
  );

  always @(negedge clk) if (req_wr || req_rd) req_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // clocked-mode access; ds_lvl is the data strobe level held during it
  task automatic sync_acc(input logic rd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic csn, input logic ds_lvl, input string tag,
                          output logic [DW-1:0] rdat);
    logic sel;
    sel = !csn;
    @(negedge clk);
    as_n = 1'b0; cs_n = csn; rw = rd; addr = a; din = d; ds_n = ds_lvl;
    @(negedge clk);
    as_n = 1'b1; cs_n = 1'b1; ds_n = 1'b1;
    chk({tag, " req_wr"}, req_wr, sel && !rd);
    chk({tag, " req_rd"}, req_rd, sel && rd);
    if (sel) chk({tag, " req_addr"}, req_addr, a);
    if (sel && !rd) chk({tag, " req_wdata"}, req_wdata, d);
    @(negedge clk);
    chk({tag, " ack low"}, ack_n, !sel);
    chk({tag, " oe"}, oe, sel && rd);
    chk({tag, " req gone"}, req_wr || req_rd, 1'b0);
    rdat = dout;
    @(negedge clk);
    chk({tag, " ack released"}, ack_n, 1'b1);
    chk({tag, " oe released"}, oe, 1'b0);
  endtask

  // strobe-framed access with a long data strobe
  task automatic async_acc(input logic rd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic csn, input string tag, output logic [DW-1:0] rdat);
    logic sel;
    int   base;
    sel = !csn;
    @(negedge clk);
    cs_n = csn; as_n = 1'b0; rw = rd; addr = a; din = d;
    @(negedge clk);
    ds_n = 1'b0; base = req_cnt;
    @(negedge clk);
    @(negedge clk);
    chk({tag, " R6 no early req"}, req_wr || req_rd, 1'b0);
    @(negedge clk);
    chk({tag, " R6 req_wr"}, req_wr, sel && !rd);
    chk({tag, " R6 req_rd"}, req_rd, sel && rd);
    if (sel) chk({tag, " R7 addr"}, req_addr, a);
    if (sel && !rd) chk({tag, " R7 wdata"}, req_wdata, d);
    @(negedge clk);
    chk({tag, " R6 ack low"}, ack_n, !sel);
    chk({tag, " R11 oe"}, oe, sel && rd);
    rdat = dout;
    repeat (6) @(negedge clk);
    chk({tag, " R8 ack held"}, ack_n, !sel);
    chk({tag, " R9 one access"}, req_cnt - base, sel ? 1 : 0);
    ds_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk({tag, " R8 ack before release"}, ack_n, !sel);
    @(negedge clk);
    chk({tag, " R8 ack released"}, ack_n, 1'b1);
    chk({tag, " R8 oe released"}, oe, 1'b0);
    as_n = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ack in reset", ack_n, 1'b1);
    chk("R1 oe in reset", oe, 1'b0);
    chk("R1 req in reset", req_wr || req_rd, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    mode = 1'b1;
    for (int i = 0; i < NREG; i++) begin
      sync_acc(1'b1, AW'(i), '0, 1'b0, 1'b1, "R1 reset read", rd_val);
      chk("R1 register resets to zero", rd_val, '0);
    end
  endtask

  task automatic t_sync_basic();
    mode = 1'b1;
    sync_acc(1'b0, 21'd3, 16'h1234, 1'b0, 1'b1, "R2 write", rd_val);
    chk("R11 write has no drive", rd_val, '0);
    sync_acc(1'b0, 21'd6, 16'hA5C3, 1'b0, 1'b1, "R2 write", rd_val);
    sync_acc(1'b1, 21'd3, '0, 1'b0, 1'b1, "R3 read", rd_val);
    chk("R3 read data reg3", rd_val, 16'h1234);
    sync_acc(1'b1, 21'd6, '0, 1'b0, 1'b1, "R3 read", rd_val);
    chk("R3 read data reg6", rd_val, 16'hA5C3);
  endtask

  task automatic t_sync_ds_ignored();
    int base;
    mode = 1'b1;
    base = req_cnt;
    @(negedge clk);
    cs_n = 1'b0; ds_n = 1'b0; rw = 1'b0; addr = 21'd2; din = 16'hDEAD;
    repeat (4) @(negedge clk);
    chk("R4 ds alone no ack", ack_n, 1'b1);
    ds_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 ds alone no req", req_cnt - base, 0);
    chk("R4 ds alone no ack after", ack_n, 1'b1);
    sync_acc(1'b0, 21'd2, 16'h0F0F, 1'b0, 1'b0, "R4 write with ds low", rd_val);
    sync_acc(1'b1, 21'd2, '0, 1'b0, 1'b0, "R4 read with ds low", rd_val);
    chk("R4 data with ds low", rd_val, 16'h0F0F);
  endtask

  task automatic t_deselected();
    mode = 1'b1;
    sync_acc(1'b0, 21'd3, 16'hFFFF, 1'b1, 1'b1, "R5 sync deselected", rd_val);
    mode = 1'b0;
    async_acc(1'b0, 21'd3, 16'hEEEE, 1'b1, "R5 async deselected", rd_val);
    mode = 1'b1;
    sync_acc(1'b1, 21'd3, '0, 1'b0, 1'b1, "R5 readback", rd_val);
    chk("R5 register unchanged", rd_val, 16'h1234);
  endtask

  task automatic t_async();
    mode = 1'b0;
    repeat (3) @(negedge clk);
    async_acc(1'b0, 21'd5, 16'h5AA5, 1'b0, "async write", rd_val);
    chk("R11 async write no drive", rd_val, '0);
    async_acc(1'b1, 21'd5, '0, 1'b0, "async read", rd_val);
    chk("R7 async read data", rd_val, 16'h5AA5);
    async_acc(1'b1, 21'd6, '0, 1'b0, "async read2", rd_val);
    chk("R7 async read reg6", rd_val, 16'hA5C3);
  endtask

  task automatic t_range();
    mode = 1'b1;
    sync_acc(1'b0, 21'h100003, 16'hBEEF, 1'b0, 1'b1, "R10 high write", rd_val);
    sync_acc(1'b0, AW'(NREG), 16'hCAFE, 1'b0, 1'b1, "R10 edge write", rd_val);
    sync_acc(1'b1, 21'd3, '0, 1'b0, 1'b1, "R10 read reg3", rd_val);
    chk("R10 no alias", rd_val, 16'h1234);
    sync_acc(1'b1, 21'h100003, '0, 1'b0, 1'b1, "R10 read high", rd_val);
    chk("R10 high reads zero", rd_val, '0);
    sync_acc(1'b1, AW'(NREG), '0, 1'b0, 1'b1, "R10 read edge", rd_val);
    chk("R10 edge reads zero", rd_val, '0);
  endtask

  initial begin
    t_reset();
    t_sync_basic();
    t_sync_ds_ignored();
    t_deselected();
    t_async();
    t_range();
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule